// File: doc/BRIEF.md
# Banked Block Refill Engine

This block is the main-memory side of a cache refill path. A cache that has missed hands it a block number, and the engine returns the four 32-bit words of that block over a single response bus, lowest word first. Each beat carries a word index, so the cache knows which slot of its line to fill. A done pulse marks the final beat. The memory behind the engine is split into four banks. Bank k stores word k of every block.

Timing is fixed by the model. One cycle goes to presenting the address, and every bank access then takes ten cycles. Moving one word across the bus takes one cycle. In interleaved mode all four banks are read at the same time after the address cycle, and the words then go out back to back. A refill therefore takes 15 cycles. In sequential mode each word waits for its own access before it is sent, so a refill takes 45 cycles. This mode exists to compare the two organisations.

The request side is a valid/ready handshake. A request is taken on a rising clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low the requester must hold or drop its request; the engine takes nothing during that time. The response side has a valid strobe and no ready. The cache must take every beat in the cycle it is shown, because a memory with fixed latency cannot be stalled.

Top module: `bank_refill_engine`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The block number and the mode are captured at that edge.
- R2: While reset is held and after it is released, the engine is idle: `busy` = 0, `req_ready` = 1, and `rsp_valid` and `rsp_last` are 0.
- R3: Cycles are counted from acceptance: the cycle after the accepting edge is cycle 1. With `seq_mode` = 0 (interleaved), word k is on the bus in cycle 12 + k, and the refill ends in cycle 15.
- R4: With `seq_mode` = 1 (sequential), word k is on the bus in cycle 12 + 11·k, and the refill ends in cycle 45.
- R5: Words go out in ascending order, from 0 to 3. During each beat, `rsp_idx` carries the index of the word on `rsp_data`.
- R6: Word k of block b comes from bank k, entry b. After reset that entry holds (b << 8) | (k << 4) | 5. For example, block 3 word 2 reads 0x00000325. Outside beats, `rsp_data` is 0.
- R7: `rsp_last` is high only together with the beat of word 3, and never at any other time.
- R8: `busy` is high from cycle 1 through the final beat, and `req_ready` is its complement. In the cycle after the final beat the engine is ready again, and a request presented in that cycle is accepted at its closing edge.
- R9: While busy, a request, a changed block number or a changed mode has no effect. The refill in flight keeps its timing and its data, and no refill follows unless a request is presented once the engine is ready.
- R10: `rsp_valid` is high only in the beat cycles given in R3 and R4. It is never high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request present |
| req_ready | output | 1 | Engine can accept a request |
| req_blk | input | ADDR_W (4) | Block number to refill |
| seq_mode | input | 1 | 0 = interleaved banks, 1 = sequential accesses |
| rsp_valid | output | 1 | A word is on `rsp_data` this cycle |
| rsp_data | output | DATA_W (32) | Returned word |
| rsp_idx | output | 2 | Index of the returned word within the block |
| rsp_last | output | 1 | Final word of the refill |
| busy | output | 1 | A refill is in progress |

## Verification
The hardest behaviour to reach from the ports is the engine's indifference to its inputs while a refill runs, combined with back-to-back reuse of the first free cycle. To get there, the stimulus keeps `req_valid` high through half of the refills, with an inverted block number and the opposite mode. It then presents the next request in the very cycle readiness returns. Every block is swept in both modes. The bench predicts the cycle, index and value of each beat arithmetically, so a stray capture or a lost or shifted beat shows up as a wrong word in a known cycle.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_BEAT
  } rf_state_e;

  // Contents that every bank entry holds after reset.
  function automatic logic [31:0] seed_word(int unsigned blk, int unsigned word);
    return 32'((blk << 8) | (word << 4) | 32'd5);
  endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_row,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage is loaded with its seed contents on reset. This block never writes it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) begin
        mem[r] <= DATA_W'(refill_pkg::seed_word(r, BANK_ID));
      end
    end
  end

  // The read register captures data when the access latency expires.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= mem[rd_row];
    end
  end

endmodule

// File: rtl/refill_seq.sv
module refill_seq #(
  parameter int ADDR_W  = 4,
  parameter int NBANK   = 4,
  parameter int ACC_LAT = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_blk,
  input  logic                     seq_mode,
  output logic                     req_ready,
  output logic                     busy,
  output logic [ADDR_W-1:0]        blk_q,
  output logic                     mode_q,
  output logic [NBANK-1:0]         rd_en,
  output logic                     beat_valid,
  output logic [$clog2(NBANK)-1:0] beat_idx,
  output logic                     beat_last
);
  import refill_pkg::*;

  localparam int IDX_W = $clog2(NBANK);
  localparam int CNT_W = $clog2(ACC_LAT + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBANK - 1);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(ACC_LAT - 1);

  rf_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] widx;
  logic             acc_done;

  assign acc_done  = (state == ST_WAIT) && (cnt == CNT_END);
  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      widx   <= '0;
      blk_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state  <= ST_ADDR;
            blk_q  <= req_blk;
            mode_q <= seq_mode;
            widx   <= '0;
          end
        end
        ST_ADDR: begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
        ST_WAIT: begin
          if (acc_done) begin
            state <= ST_BEAT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_BEAT: begin
          if (widx == IDX_LAST) begin
            state <= ST_IDLE;
          end else begin
            widx <= widx + 1'b1;
            if (mode_q) begin
              state <= ST_WAIT;
              cnt   <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Interleaved mode strobes every bank at once. Sequential mode strobes only the bank of the current word.
  for (genvar k = 0; k < NBANK; k++) begin : g_rd
    assign rd_en[k] = acc_done && (!mode_q || (widx == IDX_W'(k)));
  end

  assign beat_valid = (state == ST_BEAT);
  assign beat_idx   = widx;
  assign beat_last  = (state == ST_BEAT) && (widx == IDX_LAST);

endmodule

// File: rtl/refill_mux.sv
module refill_mux #(
  parameter int NBANK  = 4,
  parameter int DATA_W = 32
) (
  input  logic [NBANK-1:0][DATA_W-1:0] bank_q,
  input  logic                         sel_valid,
  input  logic [$clog2(NBANK)-1:0]     sel_idx,
  output logic [DATA_W-1:0]            out_data
);
  assign out_data = sel_valid ? bank_q[sel_idx] : '0;
endmodule

// File: rtl/bank_refill_engine.sv
module bank_refill_engine #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ACC_LAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_blk,
  input  logic              seq_mode,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [1:0]        rsp_idx,
  output logic              rsp_last,
  output logic              busy
);
  localparam int NBANK = 4;

  logic [ADDR_W-1:0]            blk_q;
  logic                         mode_q;
  logic [NBANK-1:0]             rd_en;
  logic [NBANK-1:0][DATA_W-1:0] bank_q;

  refill_seq #(.ADDR_W(ADDR_W), .NBANK(NBANK), .ACC_LAT(ACC_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_blk    (req_blk),
    .seq_mode   (seq_mode),
    .req_ready  (req_ready),
    .busy       (busy),
    .blk_q      (blk_q),
    .mode_q     (mode_q),
    .rd_en      (rd_en),
    .beat_valid (rsp_valid),
    .beat_idx   (rsp_idx),
    .beat_last  (rsp_last)
  );

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    refill_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_ID(k)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en[k]),
      .rd_row (blk_q),
      .rd_q   (bank_q[k])
    );
  end

  refill_mux #(.NBANK(NBANK), .DATA_W(DATA_W)) u_mux (
    .bank_q    (bank_q),
    .sel_valid (rsp_valid),
    .sel_idx   (rsp_idx),
    .out_data  (rsp_data)
  );

endmodule

// File: rtl/bank_refill_engine_chk.sv
module bank_refill_engine_chk #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ACC_LAT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        rsp_idx,
  input logic              rsp_last,
  input logic [ADDR_W-1:0] blk_q,
  input logic              mode_q
);
  localparam int NBANK    = 4;
  localparam int LAST_ILV = 1 + ACC_LAT + NBANK;
  localparam int LAST_SEQ = 1 + NBANK * (ACC_LAT + 1);
  localparam int CW       = $clog2(LAST_SEQ + 2);

  // Counts cycles since acceptance; cycle 1 is the first busy cycle.
  logic [CW-1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n)                      cyc <= '0;
    else if (req_valid && req_ready) cyc <= CW'(1);
    else if (busy)                   cyc <= cyc + 1'b1;
  end

  assert_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != busy);
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> req_ready);
  assert_ilv_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_last && !mode_q) |-> (cyc == CW'(LAST_ILV)));
  assert_seq_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_last && mode_q) |-> (cyc == CW'(LAST_SEQ)));
  assert_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last && !mode_q) |=> (rsp_valid && rsp_idx == 2'($past(rsp_idx) + 1'b1)));
  assert_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data == DATA_W'(refill_pkg::seed_word(int'(blk_q), int'(rsp_idx)))));
  assert_last_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> (rsp_valid && rsp_idx == 2'(NBANK - 1)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(blk_q) && $stable(mode_q)));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rsp_valid);

endmodule

bind bank_refill_engine bank_refill_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_LAT(ACC_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_idx   (rsp_idx),
  .rsp_last  (rsp_last),
  .blk_q     (blk_q),
  .mode_q    (mode_q)
);

// File: tb/bank_refill_engine_bench.sv
module bank_refill_engine_bench;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int ACC_LAT = 10;
  localparam int NBANK   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_blk;
  logic              seq_mode;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [1:0]        rsp_idx;
  logic              rsp_last;
  logic              busy;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bank_refill_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACC_LAT(ACC_LAT)) u_bank_refill_engine (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_blk (req_blk), .seq_mode (seq_mode), .rsp_valid (rsp_valid),
    .rsp_data (rsp_data), .rsp_idx (rsp_idx), .rsp_last (rsp_last), .busy (busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One refill, called and returning on a falling edge (R1, R3..R10).
  task automatic refill(input int blk, input bit mode, input bit noise);
    int last;
    last = mode ? 1 + NBANK * (ACC_LAT + 1) : 1 + ACC_LAT + NBANK;
    check(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_blk   = ADDR_W'(blk);
    seq_mode  = mode;
    @(posedge clk);
    @(negedge clk);
    for (int c = 1; c <= last + 1; c++) begin
      int kx;
      kx = -1;
      for (int k = 0; k < NBANK; k++) begin
        if (c == 2 + ACC_LAT + k * (mode ? ACC_LAT + 1 : 1)) kx = k;
      end
      if (c <= last) begin
        check(busy == 1'b1 && req_ready == 1'b0, "R8", "busy during refill", busy, 1);
      end else begin
        check(busy == 1'b0 && req_ready == 1'b1, "R8", "ready after last beat", req_ready, 1);
      end
      check(rsp_valid == (kx >= 0), mode ? "R4" : "R3", "beat timing", rsp_valid, kx >= 0);
      if (kx >= 0) begin
        check(rsp_idx == 2'(kx), "R5", "word index", rsp_idx, kx);
        check(rsp_data == DATA_W'((blk << 8) | (kx << 4) | 5), "R6", "word data",
              rsp_data, (blk << 8) | (kx << 4) | 5);
        check(rsp_last == (kx == NBANK - 1), "R7", "last flag", rsp_last, kx == NBANK - 1);
      end else begin
        check(rsp_last == 1'b0 && rsp_data == '0, "R10", "quiet outside beats", rsp_data, 0);
      end
      if (c <= last) begin
        // R9: a competing request with an inverted block and mode while busy
        if (noise && c < last) begin
          req_valid = 1'b1;
          req_blk   = ~ADDR_W'(blk);
          seq_mode  = ~mode;
        end else begin
          req_valid = 1'b0;
        end
        @(negedge clk);
      end
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_blk   = '0;
    seq_mode  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0 && req_ready == 1'b1 && rsp_valid == 1'b0 && rsp_last == 1'b0,
          "R2", "state during reset", {busy, req_ready, rsp_valid}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && req_ready == 1'b1 && rsp_valid == 1'b0 && rsp_last == 1'b0,
          "R2", "idle after reset", {busy, req_ready, rsp_valid}, 3'b010);
    // Back-to-back sweep over every block in both modes. Noise on alternate refills.
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < (1 << ADDR_W); b++) begin
        refill(b, m[0], b[0]);
      end
    end
    // R9/R10: nothing further was started and the bus stays quiet
    req_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b0 && busy == 1'b0, "R10", "no refill without request", rsp_valid, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule